// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps addresses issued on the CPU side of a host bridge into the address space of the PCI side. Six windows can be programmed. Each window has three registers: a CPU-side start address, a length counted in 4 KiB pages, and a PCI-side base. Once per cycle a request address can be presented with a valid strobe. One cycle later the block reports one of two results. On a hit it gives the index of the winning window and the translated address. On a miss it raises a decode-error flag.

Windows 0 and 1 take their PCI-side base as a plain byte address. They are intended for configuration space and downstream I/O, for example bases of 0xFE100000 and 0xFDFC0000. Windows 2 to 5 are memory windows and store their base in a packed form. Bits 31:4 hold the PCI page number, and bit 0 must be 1 for the window to be usable. Software programs all three register groups through a small register port that is addressed in words.

Top module: `obx_xlat_top`

## Requirements
- R1: After synchronous reset, every window register reads 0 and `rsp_valid`, `rsp_hit` and `rsp_miss` are 0.
- R2: Register offsets are byte offsets with bits 1:0 equal to 0. The size of window i is at 0x00+4i, its start at 0x18+4i and its base at 0x30+4i. A read returns the stored value on `reg_rdata` one cycle later. A read of any other offset returns 0. A write with nonzero bits 1:0 changes nothing.
- R3: A window whose size register is 0 never hits. With all registers at 0, every request misses.
- R4: Window w hits when start <= addr and (addr - start) >> 12 < size. The upper bound is exclusive.
- R5: For windows 0 and 1, the translated address is base + (addr - start). The base is taken as a byte address.
- R6: For windows 2 to 5, the translated address is ((base >> 4) << 12) + (addr - start).
- R7: A window among 2 to 5 whose base has bit 0 clear never hits.
- R8: When several windows hit, the lowest-numbered one wins, and its index appears on `rsp_win`.
- R9: A request that hits no window gives `rsp_miss`=1, `rsp_hit`=0, `rsp_win`=0 and `rsp_addr`=0 for exactly that one response cycle.
- R10: A request in the same cycle as a register write is translated with the register values from before that write. The write affects only later requests.
- R11: Every request gives exactly one response, in order, in the next cycle. A cycle without a request gives `rsp_valid`=0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW (8) | Register byte offset |
| reg_wdata | input | AW (32) | Register write data |
| reg_rdata | output | AW (32) | Register read data, valid the cycle after `reg_rd` |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW (32) | CPU-side request address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request fell inside an enabled window |
| rsp_miss | output | 1 | Request matched no window (decode error) |
| rsp_win | output | WINW (3) | Index of the winning window |
| rsp_addr | output | AW (32) | Translated PCI-side address, 0 on a miss |

## Verification
A register write and a translation request can fall in the same cycle. The bench provokes this by enabling a window, that is, writing its size from 0 to nonzero, while a request aimed at that window is presented in the same cycle. It then presents the same address again one cycle later. The scoreboard expects a miss for the first request and a hit for the second. Overlapping windows, exact lower and upper boundaries, and the enable bit of a packed base are also exercised against a reference model in the bench.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int PACK_SHIFT = 4;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_SIZE  = 2'd1,
    GRP_START = 2'd2,
    GRP_BASE  = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/obx_regfile.sv
module obx_regfile
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int AW      = 32,
  parameter int REG_AW  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic [AW-1:0]                reg_wdata,
  output logic [AW-1:0]                reg_rdata,
  output logic [NUM_WIN-1:0][AW-1:0]   size_o,
  output logic [NUM_WIN-1:0][AW-1:0]   start_o,
  output logic [NUM_WIN-1:0][AW-1:0]   base_o
);
  localparam int WORDW = REG_AW - 2;

  logic [AW-1:0] size_q  [NUM_WIN];
  logic [AW-1:0] start_q [NUM_WIN];
  logic [AW-1:0] base_q  [NUM_WIN];
  logic [AW-1:0] rdata_q;

  logic [WORDW-1:0] word;
  logic             aligned;
  reg_grp_e         grp;
  int               idx;

  assign word    = reg_addr[REG_AW-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  always_comb begin
    grp = GRP_NONE;
    idx = 0;
    if (aligned) begin
      if (int'(word) < NUM_WIN) begin
        grp = GRP_SIZE;
        idx = int'(word);
      end else if (int'(word) < 2 * NUM_WIN) begin
        grp = GRP_START;
        idx = int'(word) - NUM_WIN;
      end else if (int'(word) < 3 * NUM_WIN) begin
        grp = GRP_BASE;
        idx = int'(word) - 2 * NUM_WIN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        size_q[i]  <= '0;
        start_q[i] <= '0;
        base_q[i]  <= '0;
      end
      rdata_q <= '0;
    end else begin
      if (reg_wr) begin
        case (grp)
          GRP_SIZE:  size_q[idx]  <= reg_wdata;
          GRP_START: start_q[idx] <= reg_wdata;
          GRP_BASE:  base_q[idx]  <= reg_wdata;
          default:   ;
        endcase
      end
      if (reg_rd) begin
        case (grp)
          GRP_SIZE:  rdata_q <= size_q[idx];
          GRP_START: rdata_q <= start_q[idx];
          GRP_BASE:  rdata_q <= base_q[idx];
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata = rdata_q;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
    assign size_o[g]  = size_q[g];
    assign start_o[g] = start_q[g];
    assign base_o[g]  = base_q[g];
  end

  // R2
  unaligned_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !aligned) |=> ($stable(size_o) && $stable(start_o) && $stable(base_o)));
endmodule

// File: rtl/obx_window.sv
module obx_window
  import obx_pkg::*;
#(
  parameter int AW     = 32,
  parameter bit PACKED = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] size_i,
  input  logic [AW-1:0] base_i,
  output logic          hit_o,
  output logic [AW-1:0] xaddr_o
);
  logic [AW-1:0] offset;
  logic [AW-1:0] page_off;
  logic [AW-1:0] base_byte;
  logic          enabled;
  logic          in_range;

  assign offset   = addr_i - start_i;
  assign page_off = offset >> PAGE_SHIFT;
  assign in_range = (addr_i >= start_i) && (page_off < size_i);

  if (PACKED) begin : g_packed
    assign base_byte = (base_i >> PACK_SHIFT) << PAGE_SHIFT;
    assign enabled   = (size_i != '0) && base_i[0];
  end else begin : g_plain
    assign base_byte = base_i;
    assign enabled   = (size_i != '0);
  end

  assign hit_o   = enabled && in_range;
  assign xaddr_o = base_byte + offset;

  // R3
  zero_size_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (size_i == '0) |-> !hit_o);
  // R4
  below_start_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i < start_i) |-> !hit_o);
endmodule

// File: rtl/obx_xlat_top.sv
module obx_xlat_top
  import obx_pkg::*;
#(
  parameter int                NUM_WIN    = 6,
  parameter int                AW         = 32,
  parameter int                REG_AW     = 8,
  parameter logic [NUM_WIN-1:0] PACKED_WIN = 6'b111100,
  localparam int               WINW       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [WINW-1:0]   rsp_win,
  output logic [AW-1:0]     rsp_addr
);
  logic [NUM_WIN-1:0][AW-1:0] size_w;
  logic [NUM_WIN-1:0][AW-1:0] start_w;
  logic [NUM_WIN-1:0][AW-1:0] base_w;
  logic [NUM_WIN-1:0]         hit_w;
  logic [NUM_WIN-1:0][AW-1:0] xaddr_w;

  obx_regfile #(.NUM_WIN(NUM_WIN), .AW(AW), .REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .size_o    (size_w),
    .start_o   (start_w),
    .base_o    (base_w)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    obx_window #(.AW(AW), .PACKED(PACKED_WIN[g])) u_win (
      .clk     (clk),
      .rst     (rst),
      .addr_i  (req_addr),
      .start_i (start_w[g]),
      .size_i  (size_w[g]),
      .base_i  (base_w[g]),
      .hit_o   (hit_w[g]),
      .xaddr_o (xaddr_w[g])
    );
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  logic [WINW-1:0] sel_win;
  logic [AW-1:0]   sel_addr;
  logic            any_hit;

  always_comb begin
    sel_win  = '0;
    sel_addr = '0;
    any_hit  = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_w[i]) begin
        sel_win  = WINW'(i);
        sel_addr = xaddr_w[i];
        any_hit  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_hit;
      rsp_miss  <= req_valid && !any_hit;
      rsp_win   <= req_valid ? sel_win : '0;
      rsp_addr  <= req_valid ? sel_addr : '0;
    end
  end

  // R9
  hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_miss));
  // R9
  miss_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_addr == '0 && rsp_win == '0));
  // R11
  req_gives_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R11
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_valid || rsp_hit || rsp_miss));
  // R8
  win_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (int'(rsp_win) < NUM_WIN));
endmodule

// File: tb/sim_obx_xlat_top.sv
module sim_obx_xlat_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [2:0]  rsp_win;
  logic [31:0] rsp_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obx_xlat_top u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_win(rsp_win), .rsp_addr(rsp_addr)
  );

  typedef struct {
    logic        hit;
    logic [2:0]  win;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // reference copy of the programmed windows
  logic [31:0] m_size [NW];
  logic [31:0] m_start[NW];
  logic [31:0] m_base [NW];

  function automatic exp_t model(input logic [31:0] a, input string tag);
    exp_t e;
    e.hit = 1'b0; e.win = '0; e.addr = '0; e.tag = tag;
    for (int i = 0; i < NW; i++) begin
      logic pk;
      logic [31:0] bb;
      pk = (i >= 2);
      if (!e.hit && m_size[i] != 0 && (!pk || m_base[i][0]) &&
          a >= m_start[i] && ((a - m_start[i]) >> 12) < m_size[i]) begin
        bb = pk ? ((m_base[i] >> 4) << 12) : m_base[i];
        e.hit = 1'b1; e.win = 3'(i); e.addr = bb + (a - m_start[i]);
      end
    end
    return e;
  endfunction

  task automatic fail(input string msg);
    errors++;
    $display("FAIL %s", msg);
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int w;
    w = int'(a[7:2]);
    if (a[1:0] == 2'b00) begin
      if (w < NW) m_size[w] = d;
      else if (w < 2*NW) m_start[w-NW] = d;
      else if (w < 3*NW) m_base[w-2*NW] = d;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    model_write(a, d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] expv, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    checks++;
    if (reg_rdata !== expv)
      fail($sformatf("%s rdata@%02h actual=%08h expected=%08h", tag, a, reg_rdata, expv));
  endtask

  task automatic req(input logic [31:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back(model(a, tag));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // R10: write and request in the same cycle
  task automatic wr_and_req(input logic [7:0] wa, input logic [31:0] wd,
                            input logic [31:0] a, input string tag);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = wa; reg_wdata = wd;
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back(model(a, tag));
    model_write(wa, wd);
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        fail($sformatf("R11 unexpected response actual=valid expected=none"));
      end else begin
        e = exp_q.pop_front();
        if (rsp_hit !== e.hit || rsp_miss !== !e.hit || rsp_win !== e.win || rsp_addr !== e.addr)
          fail($sformatf("%s actual hit=%0b miss=%0b win=%0d addr=%08h expected hit=%0b miss=%0b win=%0d addr=%08h",
                         e.tag, rsp_hit, rsp_miss, rsp_win, rsp_addr,
                         e.hit, !e.hit, e.win, e.addr));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_size[i] = '0; m_start[i] = '0; m_base[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_miss !== 1'b0)
      fail($sformatf("R1 outputs actual=%0b%0b%0b expected=000", rsp_valid, rsp_hit, rsp_miss));
    rd_chk(8'h00, 32'h0, "R1 size0");
    rd_chk(8'h2C, 32'h0, "R1 start5");
    rd_chk(8'h44, 32'h0, "R1 base5");

    // R3 all windows disabled
    req(32'h0000_0000, "R3 zero regs");
    req(32'h8000_0000, "R3 zero regs");

    // window 0: plain base
    wr(8'h18, 32'h8000_0000);
    wr(8'h30, 32'hFE10_0000);
    req(32'h8000_0000, "R3 size still zero");
    wr(8'h00, 32'h0000_0010);

    // R2 register readback and ignored accesses
    rd_chk(8'h00, 32'h0000_0010, "R2 size0");
    rd_chk(8'h18, 32'h8000_0000, "R2 start0");
    rd_chk(8'h30, 32'hFE10_0000, "R2 base0");
    rd_chk(8'h48, 32'h0, "R2 unmapped");
    rd_chk(8'h1A, 32'h0, "R2 unaligned read");
    wr(8'h19, 32'h1234_5678);
    rd_chk(8'h18, 32'h8000_0000, "R2 unaligned write");

    // R4 R5 boundaries
    req(32'h8000_0000, "R4 lower edge");
    req(32'h8000_0123, "R5 plain offset");
    req(32'h8000_FFFF, "R4 last byte");
    req(32'h8001_0000, "R4 upper exclusive");
    req(32'h7FFF_FFFF, "R4 below start");

    // window 1 plain, window 3 packed overlapping it
    wr(8'h1C, 32'h9000_0000);
    wr(8'h34, 32'hFDFC_0000);
    wr(8'h04, 32'h0000_0010);
    wr(8'h24, 32'h9000_8000);
    wr(8'h3C, 32'h0040_0001);
    wr(8'h0C, 32'h0000_0010);
    req(32'h9000_0004, "R5 window1");
    req(32'h9000_8010, "R8 overlap lowest wins");
    req(32'h9001_0000, "R6 packed window3");
    req(32'h9001_7FFF, "R6 packed last byte");
    req(32'h9001_8000, "R9 miss past window3");

    // R7 packed base without enable bit, then enabled
    wr(8'h20, 32'hA000_0000);
    wr(8'h08, 32'h0000_0001);
    wr(8'h38, 32'h0050_0000);
    req(32'hA000_0040, "R7 enable bit clear");
    wr(8'h38, 32'h0050_0001);
    req(32'hA000_0040, "R7 enable bit set");

    // R10 write and request in the same cycle
    wr(8'h28, 32'hB000_0000);
    wr(8'h40, 32'h0060_0001);
    wr_and_req(8'h10, 32'h0000_0001, 32'hB000_0010, "R10 old value used");
    req(32'hB000_0010, "R10 new value used");

    // R11 back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h8000_0100; exp_q.push_back(model(32'h8000_0100, "R11 b2b 1"));
    @(negedge clk);
    req_addr = 32'hC000_0000; exp_q.push_back(model(32'hC000_0000, "R11 b2b 2"));
    @(negedge clk);
    req_addr = 32'h9000_0200; exp_q.push_back(model(32'h9000_0200, "R11 b2b 3"));
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    checks++;
    if (exp_q.size() != 0)
      fail($sformatf("R11 pending responses actual=%0d expected=0", exp_q.size()));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule